// File: doc/BRIEF.md
# Self-Checking Duplicated 2-to-4 Decoder

This block is an address decoder that checks itself while it runs. The decode logic is a binary tree of small one-to-two steering cells. The root cell is gated by the enable input, and each level of the tree splits on one address bit. Every cell exists twice, as copy A and copy B. Each copy computes a parity bit: its parity-in XOR all of its output bits. The parity-in lines of both copies are held at zero. For each cell, the two copies' parity outputs are compared. A mismatch marks that cell in a per-cell fault vector. The decoded data comes only from copy A.

All mismatches are ORed with an external error input to form a single test flag. A low test flag means no error was seen. Both copies of a cell take the same inputs, namely copy A's outputs from the cell above. As a result, a fault lights only the bit of the cell where it sits, even when its wrong data travels further down the tree. Fault-injection masks can flip any output bit of either copy of any cell, for test and demonstration. With the default two address bits there are three cells. Cell 0 is the root and splits on `addr[1]`. Cell 1 drives outputs 0 and 1. Cell 2 drives outputs 2 and 3.

Top module: `ptc_decoder`

## Requirements
- R1: A synchronous active-high reset clears `y`, `test_flag` and `cell_fault` to zero at the next rising edge, whatever the other inputs are.
- R2: With `en` high and no fault injected, `y` becomes one-hot with bit `addr` set, for every address.
- R3: With `en` low, `y` is all zeros, even when faults are injected into copy A.
- R4: Mask bit `fault_a[2*i]` flips the low-branch output (address bit 0) of copy A of cell i. Mask bit `fault_a[2*i+1]` flips its high-branch output. `fault_b` does the same for copy B. Cell 0 is the root and splits on `addr[1]`; its low branch feeds cell 1 and its high branch feeds cell 2. Cells 1 and 2 split on `addr[0]` and drive `y[1:0]` and `y[3:2]`.
- R5: `cell_fault[i]` is the XOR of the two copies' parity outputs of cell i. Both copies have parity-in 0. A single flipped output bit in either copy of cell i therefore sets `cell_fault[i]` and no other bit.
- R6: Faults to which parity is blind are not flagged. These are two flipped bits in one copy of a cell, and the same bit flipped in both copies of a cell.
- R7: A copy-A fault in the root cell reaches `y` through the tree, but only `cell_fault[0]` is set. For example, with `addr`=2, `en`=1 and only `fault_a[0]` set, `y`=4'b0101 and `cell_fault`=3'b001.
- R8: Faults in copy B never change `y`.
- R9: `test_flag` is the OR of all `cell_fault` bits and `err_in`. With no fault, `err_in` high raises `test_flag` while `cell_fault` stays zero.
- R10: All outputs are registered. They reflect the inputs sampled at a rising edge right after that edge, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Address to decode |
| en | input | 1 | Decode enable |
| err_in | input | 1 | External error term ORed into the test flag (tie to 0 in normal use) |
| fault_a | input | 2*(2**ADDR_W-1) | Per-cell output flip mask for copy A |
| fault_b | input | 2*(2**ADDR_W-1) | Per-cell output flip mask for copy B |
| y | output | 2**ADDR_W | One-hot decoded result, taken from copy A |
| test_flag | output | 1 | High when any cell's parity copies disagree or `err_in` is high |
| cell_fault | output | 2**ADDR_W-1 | Bit i high when cell i's parity outputs disagree |

## Verification
Every result of this block appears one rising edge after the inputs that cause it. This holds for the decoded word, the per-cell fault bits and the test flag alike. The driver sets the inputs on a falling edge and queues the expected triple at the same moment. The monitor pops that triple just after the next rising edge and compares all three outputs at once. Each queued item therefore matches exactly the edge that registers its stimulus. Reset cycles go through the same queue with all-zero expectations, so a reset in the middle of a run is checked with the same one-cycle timing.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  // two output rails of one steering cell: [0] low branch, [1] high branch
  typedef logic [1:0] rail_t;

  // tree depth of a cell in heap order (root = 0)
  function automatic int cell_level(input int idx);
    int lvl;
    int span;
    lvl  = 0;
    span = 1;
    while (idx >= span) begin
      idx  = idx - span;
      span = span * 2;
      lvl  = lvl + 1;
    end
    return lvl;
  endfunction

endpackage

// File: rtl/ptc_copy.sv
module ptc_copy
  import ptc_pkg::*;
(
  input  logic  cin,
  input  logic  sel,
  input  logic  par_in,
  input  rail_t flip,
  output rail_t o,
  output logic  par_out
);

  rail_t raw;

  always_comb begin
    raw[0]  = cin & ~sel;
    raw[1]  = cin & sel;
    o       = raw ^ flip;
    par_out = par_in ^ o[0] ^ o[1];
  end

endmodule

// File: rtl/ptc_pair.sv
module ptc_pair
  import ptc_pkg::*;
(
  input  logic  cin,
  input  logic  sel,
  input  logic  par_in_a,
  input  logic  par_in_b,
  input  rail_t flip_a,
  input  rail_t flip_b,
  output rail_t o,
  output logic  mism
);

  rail_t o_a;
  rail_t o_b;
  logic  pout_a;
  logic  pout_b;

  ptc_copy u_copy_a (
    .cin     (cin),
    .sel     (sel),
    .par_in  (par_in_a),
    .flip    (flip_a),
    .o       (o_a),
    .par_out (pout_a)
  );

  ptc_copy u_copy_b (
    .cin     (cin),
    .sel     (sel),
    .par_in  (par_in_b),
    .flip    (flip_b),
    .o       (o_b),
    .par_out (pout_b)
  );

  // copy B only contributes its parity; its data is never used
  assign o    = o_a;
  assign mism = pout_a ^ pout_b;

  // R5: with equal parity inputs, a mismatch means the copies' outputs differ in parity
  always_comb begin
    if (!$isunknown({par_in_a, par_in_b, o_a, o_b}) && (par_in_a == par_in_b)) begin
      a_r5_pair_parity: assert (mism == ((o_a[0] ^ o_a[1]) != (o_b[0] ^ o_b[1])));
    end
  end

endmodule

// File: rtl/ptc_decoder.sv
module ptc_decoder
  import ptc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            en,
  input  logic                            err_in,
  input  logic [2*((1<<ADDR_W)-1)-1:0]    fault_a,
  input  logic [2*((1<<ADDR_W)-1)-1:0]    fault_b,
  output logic [(1<<ADDR_W)-1:0]          y,
  output logic                            test_flag,
  output logic [(1<<ADDR_W)-2:0]          cell_fault
);

  localparam int NOUT  = 1 << ADDR_W;
  localparam int NCELL = NOUT - 1;
  localparam int NINT  = (1 << (ADDR_W - 1)) - 1;
  localparam int NLEAF = NCELL - NINT;
  localparam logic PIN_A = 1'b0;
  localparam logic PIN_B = 1'b0;

  logic [NCELL-1:0]   cell_in;
  logic [2*NCELL-1:0] cell_o;
  logic [NCELL-1:0]   mism;
  logic [NOUT-1:0]    y_c;

  assign cell_in[0] = en;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    localparam int LVL = cell_level(i);

    if (i > 0) begin : g_link
      localparam int PARENT = (i - 1) / 2;
      localparam int BRANCH = (i - 1) % 2;
      assign cell_in[i] = cell_o[2*PARENT + BRANCH];
    end

    ptc_pair u_pair (
      .cin      (cell_in[i]),
      .sel      (addr[ADDR_W-1-LVL]),
      .par_in_a (PIN_A),
      .par_in_b (PIN_B),
      .flip_a   (fault_a[2*i +: 2]),
      .flip_b   (fault_b[2*i +: 2]),
      .o        (cell_o[2*i +: 2]),
      .mism     (mism[i])
    );

    // R5: each cell's flag follows the parity of the masks applied to it
    a_r5_cell_flag: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cell_fault[i] == $past(^(fault_a[2*i +: 2] ^ fault_b[2*i +: 2])));
  end

  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    assign y_c[2*j +: 2] = cell_o[2*(NINT + j) +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y          <= '0;
      test_flag  <= 1'b0;
      cell_fault <= '0;
    end else begin
      y          <= en ? y_c : '0;
      cell_fault <= mism;
      test_flag  <= (|mism) | err_in;
    end
  end

  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (y == '0) && !test_flag && (cell_fault == '0));

  // R2: clean decode is one-hot at the address
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    (en && fault_a == '0) |=> y == (NOUT'(1) << $past(addr)));

  // R3: disabled decode is silent
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> y == '0);

  // R8: copy B cannot disturb the data path
  a_r8_copyb_data: assert property (@(posedge clk) disable iff (rst)
    (en && fault_a == '0) |=> $onehot0(y));

  // R9: external error always reaches the flag
  a_r9_ext_err: assert property (@(posedge clk) disable iff (rst)
    err_in |=> test_flag);

  // R9: no fault and no external error keeps the flag low
  a_r9_clean_low: assert property (@(posedge clk) disable iff (rst)
    (fault_a == '0 && fault_b == '0 && !err_in) |=> !test_flag && cell_fault == '0);

endmodule

// File: tb/tb_ptc_decoder.sv
`timescale 1ns/1ps
module tb_ptc_decoder;

  localparam int ADDR_W = 2;
  localparam int NOUT   = 4;
  localparam int NCELL  = 3;

  typedef struct {
    logic [NOUT-1:0]    y;
    logic               t;
    logic [NCELL-1:0]   cf;
    string              tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [ADDR_W-1:0]    addr = '0;
  logic                 en = 1'b0;
  logic                 err_in = 1'b0;
  logic [2*NCELL-1:0]   fault_a = '0;
  logic [2*NCELL-1:0]   fault_b = '0;
  logic [NOUT-1:0]      y;
  logic                 test_flag;
  logic [NCELL-1:0]     cell_fault;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  ptc_decoder #(.ADDR_W(ADDR_W)) dut (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .en         (en),
    .err_in     (err_in),
    .fault_a    (fault_a),
    .fault_b    (fault_b),
    .y          (y),
    .test_flag  (test_flag),
    .cell_fault (cell_fault)
  );

  // expected outputs from the requirements (R4 wiring, R5 parity, R9 OR)
  function automatic exp_t model(input logic r, input logic [1:0] a, input logic e,
                                 input logic x, input logic [5:0] fa,
                                 input logic [5:0] fb, input string tag);
    exp_t m;
    logic lo, hi;
    logic [3:0] yy;
    m.tag = tag;
    if (r) begin
      m.y = '0; m.t = 1'b0; m.cf = '0;
      return m;
    end
    lo = (e & ~a[1]) ^ fa[0];
    hi = (e &  a[1]) ^ fa[1];
    yy[0] = (lo & ~a[0]) ^ fa[2];
    yy[1] = (lo &  a[0]) ^ fa[3];
    yy[2] = (hi & ~a[0]) ^ fa[4];
    yy[3] = (hi &  a[0]) ^ fa[5];
    m.y = e ? yy : 4'b0000;
    for (int i = 0; i < NCELL; i++) m.cf[i] = ^(fa[2*i +: 2] ^ fb[2*i +: 2]);
    m.t = (|m.cf) | x;
    return m;
  endfunction

  task automatic drive(input logic r, input logic [1:0] a, input logic e,
                       input logic x, input logic [5:0] fa, input logic [5:0] fb,
                       input string tag);
    @(negedge clk);
    rst = r; addr = a; en = e; err_in = x; fault_a = fa; fault_b = fb;
    q.push_back(model(r, a, e, x, fa, fb, tag));
  endtask

  // monitor: results are due one edge after the stimulus (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t ex;
        ex = q.pop_front();
        checks++;
        if (y !== ex.y || test_flag !== ex.t || cell_fault !== ex.cf) begin
          errors++;
          $display("FAIL %s (R10): y=%b t=%b cf=%b expected y=%b t=%b cf=%b",
                   ex.tag, y, test_flag, cell_fault, ex.y, ex.t, ex.cf);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state out of the initial reset
    checks++;
    if (y !== '0 || test_flag !== 1'b0 || cell_fault !== '0) begin
      errors++;
      $display("FAIL R1: y=%b t=%b cf=%b expected all zero", y, test_flag, cell_fault);
    end

    // R2: clean decode of every address
    for (int a = 0; a < NOUT; a++) drive(0, 2'(a), 1, 0, '0, '0, "R2");
    // R3: disabled, with and without copy A faults
    for (int a = 0; a < NOUT; a++) drive(0, 2'(a), 0, 0, '0, '0, "R3");
    drive(0, 2'd1, 0, 0, 6'b000001, '0, "R3");
    drive(0, 2'd3, 0, 0, 6'b100000, '0, "R3");
    // R4/R5: every single copy-A flip, all addresses
    for (int b = 0; b < 2*NCELL; b++)
      for (int a = 0; a < NOUT; a++)
        drive(0, 2'(a), 1, 0, 6'(1 << b), '0, "R4/R5 copyA");
    // R5/R8: every single copy-B flip leaves y clean
    for (int b = 0; b < 2*NCELL; b++)
      for (int a = 0; a < NOUT; a++)
        drive(0, 2'(a), 1, 0, '0, 6'(1 << b), "R5/R8 copyB");
    // R7: root copy-A fault spreads into y, flags only cell 0
    drive(0, 2'd2, 1, 0, 6'b000001, '0, "R7");
    // R6: parity-blind cases
    drive(0, 2'd0, 1, 0, 6'b000011, '0, "R6 double");
    drive(0, 2'd1, 1, 0, 6'b001100, '0, "R6 double");
    drive(0, 2'd3, 1, 0, 6'b010000, 6'b010000, "R6 same-bit");
    // R9: external error alone, and together with a fault
    drive(0, 2'd1, 1, 1, '0, '0, "R9");
    drive(0, 2'd2, 0, 1, '0, '0, "R9");
    drive(0, 2'd0, 1, 1, '0, 6'b001000, "R9");
    // R1: reset in mid-run overrides faults and error
    drive(1, 2'd3, 1, 1, 6'b101010, 6'b010101, "R1");
    drive(0, 2'd3, 1, 0, '0, '0, "R2");
    drive(0, 2'd0, 1, 0, '0, '0, "R2");

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule